// File: doc/BRIEF.md
# RISC Integer ALU with Compare

This block is the integer execution unit of a 32-bit load/store RISC core. It is purely combinational. From two register operands, a 16-bit immediate, a 5-bit shift amount and a 4-bit operation code it forms one 32-bit result and a flag that is high when that result is zero.

A branch-on-equal decision therefore only needs a subtract followed by a look at the flag. The block covers:

- wrapping add and subtract;
- AND, OR and NOR, where NOR with a zero operand serves as bitwise NOT;
- logical shifts in both directions with zero fill;
- signed and unsigned set-less-than, which yield 0 or 1;
- placement of a constant in the upper half-word;
- immediate forms of add, compare, AND and OR.

Signed immediates are widened by copying bit 15. The two bitwise immediates are widened with zeros. There is no subtract-immediate; a negative constant fed to add-immediate takes its place.

The core places the block between its register-read and write-back stages. Decode of the instruction word into the operation code, overflow traps and multiply/divide all live elsewhere.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives a+b and code 1 (subtract) gives a-b, both modulo 2^32 with no overflow indication.
- R2: Code 2 gives a AND b, code 3 gives a OR b, code 4 gives NOT (a OR b); code 4 with b equal to zero yields the bitwise inverse of a.
- R3: Code 5 shifts operand b left by shamt and code 6 shifts operand b right by shamt, vacated bit positions filled with 0; operand a is ignored.
- R4: Code 7 yields 1 when a is less than b as two's-complement numbers and 0 otherwise (0xFFFFFFFF vs 0x00000001 gives 1), bits 31..1 always 0.
- R5: Code 8 yields 1 when a is less than b as unsigned magnitudes and 0 otherwise (0xFFFFFFFF vs 0x00000001 gives 0).
- R6: Code 9 places the 16-bit immediate in result bits 31..16 and clears bits 15..0.
- R7: Code 10 adds a to the immediate widened with its bit 15 copied upward, so a negative constant subtracts.
- R8: Code 11 compares a with the sign-widened immediate as signed values; code 12 compares a with the sign-widened immediate as unsigned values; each yields 0 or 1.
- R9: Code 13 gives a AND the zero-widened immediate, code 14 gives a OR the zero-widened immediate.
- R10: zero_o is 1 exactly when result_o is all zeros; subtract of equal operands raises it.
- R11: Code 15 is reserved and yields a zero result (zero_o high).
- R12: Immediate-form codes (9 to 14) ignore b_i; register-form codes (0 to 8) ignore imm_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand, also the value shifted |
| shamt_i | input | 5 | Shift distance for codes 5 and 6 |
| imm_i | input | 16 | Immediate constant for codes 9 to 14 |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The checker evaluates its rules whenever the inputs or result change. It takes for granted that all four inputs are known two-state values held steady while the combinational result settles, and that each operation code maps to its documented meaning. The stimulus meets this by changing inputs only on the falling clock edge and reading outputs just after the next rising edge, never mid-change. Vectors push the operands to the signed and unsigned extremes: most-negative against most-positive, shift amounts of 0 and 31, and immediates with bit 15 set. The reserved code is used only in its own directed case.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

    localparam int WORD_W = 32;
    localparam int IMM_W  = 16;
    localparam int SH_W   = $clog2(WORD_W);
    localparam int OP_W   = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_NOR   = 4'd4,
        OP_SLL   = 4'd5,
        OP_SRL   = 4'd6,
        OP_SLT   = 4'd7,
        OP_SLTU  = 4'd8,
        OP_UPPER = 4'd9,
        OP_ADDI  = 4'd10,
        OP_SLTI  = 4'd11,
        OP_SLTIU = 4'd12,
        OP_ANDI  = 4'd13,
        OP_ORI   = 4'd14,
        OP_RSVD  = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        U_ARITH,
        U_LOGIC,
        U_SHIFT,
        U_CMP,
        U_UPPER,
        U_NONE
    } unit_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_NOR
    } logic_e;

    typedef struct packed {
        unit_e  unit;
        logic   use_imm;
        logic   imm_signed;
        logic   subtract;
        logic   cmp_signed;
        logic   shift_left;
        logic_e lop;
    } ctl_t;

    function automatic ctl_t decode(alu_op_e op);
        ctl_t c;
        c.unit       = U_NONE;
        c.use_imm    = 1'b0;
        c.imm_signed = 1'b0;
        c.subtract   = 1'b0;
        c.cmp_signed = 1'b0;
        c.shift_left = 1'b0;
        c.lop        = LG_AND;
        case (op)
            OP_ADD:   c.unit = U_ARITH;
            OP_SUB:   begin c.unit = U_ARITH; c.subtract = 1'b1; end
            OP_AND:   begin c.unit = U_LOGIC; c.lop = LG_AND; end
            OP_OR:    begin c.unit = U_LOGIC; c.lop = LG_OR;  end
            OP_NOR:   begin c.unit = U_LOGIC; c.lop = LG_NOR; end
            OP_SLL:   begin c.unit = U_SHIFT; c.shift_left = 1'b1; end
            OP_SRL:   c.unit = U_SHIFT;
            OP_SLT:   begin c.unit = U_CMP; c.subtract = 1'b1; c.cmp_signed = 1'b1; end
            OP_SLTU:  begin c.unit = U_CMP; c.subtract = 1'b1; end
            OP_UPPER: c.unit = U_UPPER;
            OP_ADDI:  begin c.unit = U_ARITH; c.use_imm = 1'b1; c.imm_signed = 1'b1; end
            OP_SLTI:  begin
                c.unit = U_CMP; c.use_imm = 1'b1; c.imm_signed = 1'b1;
                c.subtract = 1'b1; c.cmp_signed = 1'b1;
            end
            OP_SLTIU: begin
                c.unit = U_CMP; c.use_imm = 1'b1; c.imm_signed = 1'b1;
                c.subtract = 1'b1;
            end
            OP_ANDI:  begin c.unit = U_LOGIC; c.use_imm = 1'b1; c.lop = LG_AND; end
            OP_ORI:   begin c.unit = U_LOGIC; c.use_imm = 1'b1; c.lop = LG_OR;  end
            default:  c.unit = U_NONE;
        endcase
        return c;
    endfunction

    function automatic word_t widen_imm(logic [IMM_W-1:0] imm, logic sgn);
        return {{(WORD_W-IMM_W){sgn & imm[IMM_W-1]}}, imm};
    endfunction

    function automatic word_t place_upper(logic [IMM_W-1:0] imm);
        return {imm, {(WORD_W-IMM_W){1'b0}}};
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    assign sum_o   = full[W-1:0];
    assign carry_o = full[W];
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp (
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic diff_msb_i,
    input  logic carry_i,
    input  logic signed_i,
    output logic lt_o
);
    logic lt_signed;
    logic lt_unsigned;

    // differing signs: the negative operand is the smaller one
    assign lt_signed   = (a_msb_i ^ b_msb_i) ? a_msb_i : diff_msb_i;
    // a - b borrows exactly when a < b as magnitudes
    assign lt_unsigned = ~carry_i;
    assign lt_o = signed_i ? lt_signed : lt_unsigned;
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_e       lop_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        case (lop_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_NOR:  y_o = ~(a_i | b_i);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    output logic [W-1:0]  y_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = val_i;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int DIST = 2 ** i;
        logic [W-1:0] moved;
        assign moved = left_i ? (stage[i] << DIST) : (stage[i] >> DIST);
        assign stage[i+1] = amt_i[i] ? moved : stage[i];
    end

    assign y_o = stage[SW];
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_core_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [WORD_W-1:0] result_o,
    output logic              zero_o
);
    ctl_t  ctl;
    word_t opnd_b;
    word_t arith_y;
    logic  arith_carry;
    word_t logic_y;
    word_t shift_y;
    logic  lt;

    assign ctl    = decode(alu_op_e'(op_i));
    assign opnd_b = ctl.use_imm ? widen_imm(imm_i, ctl.imm_signed) : b_i;

    alu_addsub #(.W(WORD_W)) u_addsub (
        .a_i     (a_i),
        .b_i     (opnd_b),
        .sub_i   (ctl.subtract),
        .sum_o   (arith_y),
        .carry_o (arith_carry)
    );

    alu_cmp u_cmp (
        .a_msb_i    (a_i[WORD_W-1]),
        .b_msb_i    (opnd_b[WORD_W-1]),
        .diff_msb_i (arith_y[WORD_W-1]),
        .carry_i    (arith_carry),
        .signed_i   (ctl.cmp_signed),
        .lt_o       (lt)
    );

    alu_logic #(.W(WORD_W)) u_logic (
        .a_i   (a_i),
        .b_i   (opnd_b),
        .lop_i (ctl.lop),
        .y_o   (logic_y)
    );

    alu_shift #(.W(WORD_W), .SW(SH_W)) u_shift (
        .val_i  (b_i),
        .amt_i  (shamt_i),
        .left_i (ctl.shift_left),
        .y_o    (shift_y)
    );

    always_comb begin
        case (ctl.unit)
            U_ARITH: result_o = arith_y;
            U_LOGIC: result_o = logic_y;
            U_SHIFT: result_o = shift_y;
            U_CMP:   result_o = {{(WORD_W-1){1'b0}}, lt};
            U_UPPER: result_o = place_upper(imm_i);
            default: result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_core_pkg::*;
(
    input logic [WORD_W-1:0] a_i,
    input logic [WORD_W-1:0] b_i,
    input logic [SH_W-1:0]   shamt_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [OP_W-1:0]   op_i,
    input logic [WORD_W-1:0] result_o,
    input logic              zero_o
);
    word_t sext_imm;
    assign sext_imm = {{(WORD_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};

    always_comb begin
        if (op_i == OP_SUB)
            p_sub_inverse_r1: assert (result_o + b_i == a_i);
        if (op_i == OP_NOR)
            p_nor_disjoint_r2: assert (((result_o & (a_i | b_i)) == '0) &&
                                       ((result_o | a_i | b_i) == '1));
        if (op_i == OP_SLL)
            p_sll_fill_r3: assert ((result_o & ((word_t'(1) << shamt_i) - word_t'(1))) == '0);
        if (op_i == OP_SRL)
            p_srl_fill_r3: assert ((result_o & ~({WORD_W{1'b1}} >> shamt_i)) == '0);
        if (op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_SLTI || op_i == OP_SLTIU)
            p_cmp_bool_r4: assert (result_o[WORD_W-1:1] == '0);
        if ((op_i == OP_SLT || op_i == OP_SLTU) && a_i == b_i)
            p_cmp_equal_r5: assert (result_o == '0);
        if (op_i == OP_UPPER)
            p_upper_place_r6: assert (result_o[IMM_W-1:0] == '0 &&
                                      result_o[WORD_W-1:WORD_W-IMM_W] == imm_i);
        if (op_i == OP_ADDI)
            p_addi_sext_r7: assert (result_o - a_i == sext_imm);
        if (op_i == OP_ANDI)
            p_andi_zext_r9: assert (result_o[WORD_W-1:IMM_W] == '0);
        if (op_i == OP_SUB && a_i == b_i)
            p_sub_eq_zero_r10: assert (zero_o);
        if (op_i == OP_RSVD)
            p_rsvd_zero_r11: assert (result_o == '0 && zero_o);
    end
endmodule

bind alu_core alu_core_chk u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .imm_i    (imm_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic [3:0]  op;
    logic [31:0] res;
    logic        zf;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu_core u0 (
        .a_i(a), .b_i(b), .shamt_i(sh), .imm_i(imm), .op_i(op),
        .result_o(res), .zero_o(zf)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [15:0] imm;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  16'h0000, 32'h80000000}, // R1
        '{4'd0,  32'hFFFFFFFF, 32'h00000002, 5'd0,  16'h0000, 32'h00000001}, // R1 wrap
        '{4'd1,  32'h00000005, 32'h00000007, 5'd0,  16'h0000, 32'hFFFFFFFE}, // R1
        '{4'd2,  32'h00003C00, 32'h00000DC0, 5'd0,  16'h0000, 32'h00000C00}, // R2
        '{4'd3,  32'h00003C00, 32'h00000DC0, 5'd0,  16'h0000, 32'h00003DC0}, // R2
        '{4'd4,  32'h00003C00, 32'h00000000, 5'd0,  16'h0000, 32'hFFFFC3FF}, // R2 not
        '{4'd5,  32'h12345678, 32'h0000000B, 5'd4,  16'h0000, 32'h000000B0}, // R3
        '{4'd5,  32'h00000000, 32'h80000001, 5'd31, 16'h0000, 32'h80000000}, // R3
        '{4'd6,  32'hFFFFFFFF, 32'h80000000, 5'd31, 16'h0000, 32'h00000001}, // R3
        '{4'd6,  32'h00000000, 32'hF0000000, 5'd4,  16'h0000, 32'h0F000000}, // R3
        '{4'd7,  32'hFFFFFFFF, 32'h00000001, 5'd0,  16'h0000, 32'h00000001}, // R4
        '{4'd7,  32'h00000001, 32'hFFFFFFFF, 5'd0,  16'h0000, 32'h00000000}, // R4
        '{4'd7,  32'h80000000, 32'h7FFFFFFF, 5'd0,  16'h0000, 32'h00000001}, // R4
        '{4'd8,  32'hFFFFFFFF, 32'h00000001, 5'd0,  16'h0000, 32'h00000000}, // R5
        '{4'd8,  32'h00000001, 32'hFFFFFFFF, 5'd0,  16'h0000, 32'h00000001}, // R5
        '{4'd8,  32'h00000005, 32'h00000005, 5'd0,  16'h0000, 32'h00000000}, // R5
        '{4'd9,  32'hFFFFFFFF, 32'h00000000, 5'd0,  16'h003D, 32'h003D0000}, // R6
        '{4'd10, 32'h0000000A, 32'h00000000, 5'd0,  16'hFFFF, 32'h00000009}, // R7
        '{4'd10, 32'h00000000, 32'h00000000, 5'd0,  16'h8000, 32'hFFFF8000}, // R7
        '{4'd11, 32'hFFFFFFFE, 32'h00000000, 5'd0,  16'hFFFF, 32'h00000001}, // R8
        '{4'd12, 32'h00001000, 32'h00000000, 5'd0,  16'hFFFF, 32'h00000001}, // R8
        '{4'd12, 32'hFFFFFFFF, 32'h00000000, 5'd0,  16'hFFFF, 32'h00000000}, // R8
        '{4'd13, 32'hFFFFFFFF, 32'h00000000, 5'd0,  16'h8001, 32'h00008001}, // R9
        '{4'd14, 32'h007D0000, 32'h00000000, 5'd0,  16'h0900, 32'h007D0900}, // R9
        '{4'd1,  32'h00001234, 32'h00001234, 5'd0,  16'h0000, 32'h00000000}, // R10
        '{4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7,  16'hFFFF, 32'h00000000}  // R11
    };

    localparam string TAGS [NV] = '{
        "R1", "R1", "R1", "R2", "R2", "R2", "R3", "R3", "R3", "R3",
        "R4", "R4", "R4", "R5", "R5", "R5", "R6", "R7", "R7", "R8",
        "R8", "R8", "R9", "R9", "R10", "R11"
    };

    task automatic apply(input logic [3:0] o, input logic [31:0] va, input logic [31:0] vb,
                         input logic [4:0] s, input logic [15:0] im);
        @(negedge clk);
        op = o; a = va; b = vb; sh = s; imm = im;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] exp_res);
        checks++;
        if (res !== exp_res) begin
            errors++;
            $display("FAIL %s result actual=%h expected=%h", tag, res, exp_res);
        end
        checks++;
        if (zf !== (exp_res == 32'h0)) begin
            errors++;
            $display("FAIL %s zero actual=%b expected=%b", tag, zf, exp_res == 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        op = 4'd0; a = '0; b = '0; sh = '0; imm = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // idle state after reset: add of zeros, R10 flag high
        check("R10", 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh, VECS[i].imm);
            check(TAGS[i], VECS[i].exp);
        end

        // R12: add-immediate ignores b_i
        apply(4'd10, 32'h00000100, 32'hDEADBEEF, 5'd0, 16'hFFF0);
        check("R12", 32'h000000F0);
        apply(4'd10, 32'h00000100, 32'h00000000, 5'd0, 16'hFFF0);
        check("R12", 32'h000000F0);
        // R12: register add ignores imm_i
        apply(4'd0, 32'h00000003, 32'h00000004, 5'd0, 16'hFFFF);
        check("R12", 32'h00000007);
        // R3: shift ignores operand a and a zero shift passes b through
        apply(4'd6, 32'hFFFFFFFF, 32'hA5A5A5A5, 5'd0, 16'h0000);
        check("R3", 32'hA5A5A5A5);
        // R9: ori with bit 15 set does not widen with ones
        apply(4'd14, 32'h00000000, 32'hFFFFFFFF, 5'd0, 16'h8000);
        check("R9", 32'h00008000);
        // R8: slti equal values give 0
        apply(4'd11, 32'hFFFF8000, 32'h00000000, 5'd0, 16'h8000);
        check("R8", 32'h00000000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule